// File: doc/BRIEF.md
# Cell Fault Alarm Debounce Controller

This block is the digital control core of a monitor for a series stack of three to five rechargeable cells. Analog comparators report three per-cell conditions: at or above the overvoltage detect level, below the overvoltage release level, and at or below the open-wire level. A prescaler sets the monitoring period. On each monitoring tick the block samples these flags. Cells that the stack does not populate are masked out. The block then filters overvoltage and open-wire faults with separate consecutive-sample counters. The two filters use different rules. The overvoltage filter tolerates a single clean sample and releases on the first sample that shows every cell below the release level. The open-wire filter restarts on any clean sample and also needs a counted run of clean samples to release.

Two supply-comparison flags move the block into and out of a quick-test mode. In that mode the monitoring period is shorter and both filter delays are cut to at most one cycle. The alarm output is the OR of the two faults. It can run as push-pull, sink-only or source-only, and its polarity can be inverted. For the sink-only and source-only styles, an output-enable marks when the pad actually drives.

Top module: `cell_alarm_ctrl`

## Requirements
- R1: A monitoring tick occurs once every CYC_NORM clocks in normal mode and once every CYC_QUICK clocks in quick-test mode. The first tick after reset, and the first tick after any mode change, comes one full period of the new mode later. Fault state changes only on the clock edge that ends a tick cycle.
- R2: Only the lowest NCELL-MIN_CELLS inputs can be unused (cell 0 is the lowest). A cell i in that range is unused when any tie flag tied_i[j] with j >= i is set. The flags of unused cells have no effect on either fault.
- R3: Overvoltage is flagged on the tick that completes D+1 consecutive samples with at least one active cell's ov_hi_i set. D is the effective overvoltage delay.
- R4: While overvoltage is not flagged, one sample with no active ov_hi_i set leaves the count unchanged. A second such sample in a row clears the count.
- R5: Once overvoltage is flagged, it clears on the first tick at which every active cell has rel_lo_i set.
- R6: Open-wire is flagged on the tick that completes D+1 consecutive samples with at least one active cell's ow_lo_i set, where D is the effective open-wire delay. Any sample with no active ow_lo_i set clears the count.
- R7: Once open-wire is flagged, it clears after D+1 consecutive samples with no active ow_lo_i set. Any sample with an active ow_lo_i set restarts that count.
- R8: Delay inputs are in cycles, from 0 to 13. A value above 13 is treated as 13.
- R9: sup_hi_i high sets quick-test mode at the next edge. sup_lo_i high, with sup_hi_i low, clears it. In quick-test mode each effective delay is the smaller of the clamped setting and 1.
- R10: The alarm is asserted when either fault is flagged. Let a = fault XOR inv_i. style_i selects the output: 0 or 3 is push-pull, with alarm_o = not a and alarm_oe_o = 1. 1 is sink-only, with alarm_o = 0 and alarm_oe_o = a. 2 is source-only, with alarm_o = 1 and alarm_oe_o = a.
- R11: Reset clears both faults, both counters and quick-test mode, and restarts the tick prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ov_hi_i | input | NCELL | Cell at or above overvoltage detect level |
| rel_lo_i | input | NCELL | Cell below overvoltage release level |
| ow_lo_i | input | NCELL | Cell at or below open-wire level |
| tied_i | input | NCELL-MIN_CELLS | Low monitor input tied to supply |
| sup_hi_i | input | 1 | Supply exceeds top cell by more than the entry margin |
| sup_lo_i | input | 1 | Supply exceeds top cell by less than the exit margin |
| ov_dly_i | input | DLY_W | Overvoltage delay setting, cycles |
| ow_dly_i | input | DLY_W | Open-wire delay setting, cycles |
| inv_i | input | 1 | Invert alarm polarity |
| style_i | input | 2 | Output style select |
| alarm_o | output | 1 | Alarm level |
| alarm_oe_o | output | 1 | Alarm drive enable |

## Verification
The properties take the comparator flags to be consistent: a cell at or above the detect level is never also reported below the release level. They also take sup_hi_i and sup_lo_i never to be high together, and CYC_QUICK to be at least 2. The random stimulus clears rel_lo_i for any cell whose ov_hi_i it sets, and drives the two supply flags as exclusive single-sample pulses. The tie flags are randomised freely, because the masking rule covers every pattern.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  typedef enum logic [1:0] {
    STY_PUSH = 2'd0,
    STY_SINK = 2'd1,
    STY_SRC  = 2'd2,
    STY_ALT  = 2'd3
  } alarm_style_e;
endpackage

// File: rtl/cfa_tick_gen.sv
module cfa_tick_gen #(
  parameter int CYC_NORM  = 13107,
  parameter int CYC_QUICK = 3277
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic quick_i,
  input  logic quick_nxt_i,
  output logic tick_o
);
  localparam int PW = (CYC_NORM > 1) ? $clog2(CYC_NORM) : 1;
  localparam logic [PW-1:0] NP = PW'(CYC_NORM - 1);
  localparam logic [PW-1:0] QP = PW'(CYC_QUICK - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= NP;
    end else if (quick_nxt_i != quick_i) begin
      // restart the period on a mode change
      cnt_q <= quick_nxt_i ? QP : NP;
    end else if (tick_o) begin
      cnt_q <= quick_i ? QP : NP;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfa_ov_filter.sv
module cfa_ov_filter #(
  parameter int DLY_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic             clear_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             miss_q;
  logic             fault_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             reach;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign reach   = (32'(cnt_nxt) > 32'(dly_i));
  assign fault_o = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
    end else if (tick_i) begin
      if (!fault_q) begin
        if (hit_i) begin
          miss_q <= 1'b0;
          if (reach) begin
            fault_q <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nxt[CNT_W-1:0];
          end
        end else if (miss_q) begin
          // second clean sample in a row
          cnt_q  <= '0;
          miss_q <= 1'b0;
        end else begin
          miss_q <= 1'b1;
        end
      end else if (clear_i) begin
        fault_q <= 1'b0;
        cnt_q   <= '0;
        miss_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfa_ow_filter.sv
module cfa_ow_filter #(
  parameter int DLY_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             reach;
  logic             agree;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign reach   = (32'(cnt_nxt) > 32'(dly_i));
  // sample points toward the opposite state
  assign agree   = hit_i ^ fault_q;
  assign fault_o = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (tick_i) begin
      if (agree) begin
        if (reach) begin
          fault_q <= ~fault_q;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_nxt[CNT_W-1:0];
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/cfa_alarm_drv.sv
module cfa_alarm_drv
  import cfa_pkg::*;
(
  input  logic       fault_i,
  input  logic       inv_i,
  input  logic [1:0] style_i,
  output logic       alarm_o,
  output logic       oe_o
);
  logic asrt;
  alarm_style_e sty;

  assign asrt = fault_i ^ inv_i;
  assign sty  = alarm_style_e'(style_i);

  always_comb begin
    unique case (sty)
      STY_SINK: begin
        alarm_o = 1'b0;
        oe_o    = asrt;
      end
      STY_SRC: begin
        alarm_o = 1'b1;
        oe_o    = asrt;
      end
      default: begin
        alarm_o = ~asrt;
        oe_o    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cell_alarm_ctrl.sv
module cell_alarm_ctrl #(
  parameter int NCELL     = 5,
  parameter int MIN_CELLS = 3,
  parameter int DLY_W     = 4,
  parameter int MAX_DLY   = 13,
  parameter int CYC_NORM  = 13107,
  parameter int CYC_QUICK = 3277,
  localparam int OPT      = NCELL - MIN_CELLS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCELL-1:0] ov_hi_i,
  input  logic [NCELL-1:0] rel_lo_i,
  input  logic [NCELL-1:0] ow_lo_i,
  input  logic [OPT-1:0]   tied_i,
  input  logic             sup_hi_i,
  input  logic             sup_lo_i,
  input  logic [DLY_W-1:0] ov_dly_i,
  input  logic [DLY_W-1:0] ow_dly_i,
  input  logic             inv_i,
  input  logic [1:0]       style_i,
  output logic             alarm_o,
  output logic             alarm_oe_o
);
  localparam int CNT_W = $clog2(MAX_DLY + 1);

  logic [NCELL-1:0] active;
  logic             quick_q, quick_d;
  logic             tick;
  logic             any_ov, all_rel, any_ow;
  logic [DLY_W-1:0] ov_dly_eff, ow_dly_eff;
  logic             ov_fault, ow_fault;

  // a tie on input j leaves every cell at or below j unused
  for (genvar i = 0; i < NCELL; i++) begin : g_mask
    if (i >= OPT) begin : g_fixed
      assign active[i] = 1'b1;
    end else begin : g_opt
      assign active[i] = ~|tied_i[OPT-1:i];
    end
  end

  assign any_ov  = |(ov_hi_i & active);
  assign all_rel = &(rel_lo_i | ~active);
  assign any_ow  = |(ow_lo_i & active);

  function automatic logic [DLY_W-1:0] eff_dly(input logic [DLY_W-1:0] d, input logic q);
    logic [DLY_W-1:0] c;
    c = (32'(d) > MAX_DLY) ? DLY_W'(MAX_DLY) : d;
    if (q && (c > DLY_W'(1))) c = DLY_W'(1);
    return c;
  endfunction

  assign ov_dly_eff = eff_dly(ov_dly_i, quick_q);
  assign ow_dly_eff = eff_dly(ow_dly_i, quick_q);

  always_comb begin
    if (sup_hi_i)      quick_d = 1'b1;
    else if (sup_lo_i) quick_d = 1'b0;
    else               quick_d = quick_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quick_q <= 1'b0;
    else         quick_q <= quick_d;
  end

  cfa_tick_gen #(.CYC_NORM(CYC_NORM), .CYC_QUICK(CYC_QUICK)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .quick_i(quick_q), .quick_nxt_i(quick_d), .tick_o(tick)
  );

  cfa_ov_filter #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_ov (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .hit_i(any_ov), .clear_i(all_rel),
    .dly_i(ov_dly_eff), .fault_o(ov_fault)
  );

  cfa_ow_filter #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_ow (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .hit_i(any_ow),
    .dly_i(ow_dly_eff), .fault_o(ow_fault)
  );

  cfa_alarm_drv u_drv (
    .fault_i(ov_fault | ow_fault), .inv_i(inv_i), .style_i(style_i),
    .alarm_o(alarm_o), .oe_o(alarm_oe_o)
  );
endmodule

// File: rtl/cell_alarm_chk.sv
module cell_alarm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick,
  input logic       ov_fault,
  input logic       ow_fault,
  input logic       quick_q,
  input logic       all_rel,
  input logic       sup_hi_i,
  input logic       sup_lo_i,
  input logic       inv_i,
  input logic [1:0] style_i,
  input logic       alarm_o,
  input logic       alarm_oe_o
);
  a_r1_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  a_r1_ov_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(ov_fault));

  a_r1_ow_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(ow_fault));

  a_r5_ov_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ov_fault && all_rel) |=> !ov_fault);

  a_r9_quick_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_hi_i |=> quick_q);

  a_r9_quick_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_lo_i && !sup_hi_i) |=> !quick_q);

  a_r10_push_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == 2'd0 || style_i == 2'd3) |-> alarm_oe_o);

  a_r10_push_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == 2'd0 && !inv_i) |-> (alarm_o == !(ov_fault || ow_fault)));

  a_r10_sink_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (style_i == 2'd1) |-> !alarm_o);
endmodule

bind cell_alarm_ctrl cell_alarm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .ov_fault(ov_fault), .ow_fault(ow_fault),
  .quick_q(quick_q), .all_rel(all_rel), .sup_hi_i(sup_hi_i), .sup_lo_i(sup_lo_i),
  .inv_i(inv_i), .style_i(style_i), .alarm_o(alarm_o), .alarm_oe_o(alarm_oe_o)
);

// File: tb/cell_alarm_ctrl_test.sv
module cell_alarm_ctrl_test;
  localparam int NC = 5, MINC = 3, OPT = NC - MINC, DW = 4, MAXD = 13, CN = 8, CQ = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] ov = '0, rel = '1, ow = '0;
  logic [OPT-1:0] tied = '0;
  logic sup_hi = 1'b0, sup_lo = 1'b0, inv = 1'b0;
  logic [DW-1:0] ov_dly = '0, ow_dly = '0;
  logic [1:0] style = 2'd0;
  logic alarm, oe;

  int checks = 0, errors = 0;
  int m_cnt, m_ovc, m_owc;
  logic m_quick, m_ovf, m_ovm, m_owf, m_tick;

  always #2 clk = ~clk;

  cell_alarm_ctrl #(.NCELL(NC), .MIN_CELLS(MINC), .DLY_W(DW), .MAX_DLY(MAXD),
                    .CYC_NORM(CN), .CYC_QUICK(CQ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ov_hi_i(ov), .rel_lo_i(rel), .ow_lo_i(ow), .tied_i(tied),
    .sup_hi_i(sup_hi), .sup_lo_i(sup_lo), .ov_dly_i(ov_dly), .ow_dly_i(ow_dly),
    .inv_i(inv), .style_i(style), .alarm_o(alarm), .alarm_oe_o(oe)
  );

  function automatic logic [NC-1:0] m_active(input logic [OPT-1:0] t);
    logic [NC-1:0] a;
    for (int i = 0; i < NC; i++) begin
      a[i] = 1'b1;
      for (int j = i; j < OPT; j++) if (t[j]) a[i] = 1'b0;
    end
    return a;
  endfunction

  function automatic int m_eff(input logic [DW-1:0] d, input logic q);
    int c;
    c = (int'(d) > MAXD) ? MAXD : int'(d);
    if (q && c > 1) c = 1;
    return c;
  endfunction

  function automatic logic [1:0] m_out(input logic f, input logic iv, input logic [1:0] s);
    logic a;
    a = f ^ iv;
    case (s)
      2'd1:    return {1'b0, a};
      2'd2:    return {1'b1, a};
      default: return {~a, 1'b1};
    endcase
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = CN - 1; m_quick = 0; m_ovf = 0; m_ovm = 0; m_ovc = 0; m_owf = 0; m_owc = 0;
  endtask

  task automatic step(input string tag);
    logic [NC-1:0] a;
    logic nq, aov, arel, aow;
    int od, wd;
    a = m_active(tied);
    aov = |(ov & a); arel = &(rel | ~a); aow = |(ow & a);
    od = m_eff(ov_dly, m_quick); wd = m_eff(ow_dly, m_quick);
    m_tick = (m_cnt == 0);
    if (m_tick) begin
      if (!m_ovf) begin
        if (aov) begin
          m_ovm = 0;
          if (m_ovc + 1 > od) begin m_ovf = 1; m_ovc = 0; end else m_ovc++;
        end else if (m_ovm) begin m_ovc = 0; m_ovm = 0; end
        else m_ovm = 1;
      end else if (arel) begin m_ovf = 0; m_ovc = 0; m_ovm = 0; end
      if (!m_owf) begin
        if (aow) begin if (m_owc + 1 > wd) begin m_owf = 1; m_owc = 0; end else m_owc++; end
        else m_owc = 0;
      end else begin
        if (!aow) begin if (m_owc + 1 > wd) begin m_owf = 0; m_owc = 0; end else m_owc++; end
        else m_owc = 0;
      end
    end
    nq = sup_hi ? 1'b1 : (sup_lo ? 1'b0 : m_quick);
    if (nq != m_quick) m_cnt = (nq ? CQ : CN) - 1;
    else if (m_tick)   m_cnt = (m_quick ? CQ : CN) - 1;
    else               m_cnt--;
    m_quick = nq;
    @(posedge clk); @(negedge clk);
    check(tag, {alarm, oe}, m_out(m_ovf | m_owf, inv, style));
  endtask

  // hold inputs until one monitoring tick has been taken
  task automatic sample(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      m_tick = 0;
      while (!m_tick) step(tag);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; m_reset();
    @(posedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    m_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    check("R11 reset idle", {alarm, oe}, 2'b11);

    // R3: delay 5 needs 6 samples
    ov_dly = 5; ow_dly = 13;
    ov = 5'b10000; rel = 5'b01111;
    sample("R3", 5);
    check("R3 before count", {alarm, oe}, 2'b11);
    sample("R3", 1);
    check("R3 declared", {alarm, oe}, 2'b01);

    // R5: release only when every active cell is below release level
    ov = '0; rel = 5'b01111;
    sample("R5", 3);
    check("R5 held", {alarm, oe}, 2'b01);
    rel = '1;
    sample("R5", 1);
    check("R5 released", {alarm, oe}, 2'b11);

    // R4: single clean sample tolerated
    ov = 5'b00100; rel = 5'b11011; sample("R4", 3);
    ov = '0; rel = '1;              sample("R4", 1);
    ov = 5'b00100; rel = 5'b11011; sample("R4", 2);
    check("R4 hold count", {alarm, oe}, 2'b11);
    sample("R4", 1);
    check("R4 after hold", {alarm, oe}, 2'b01);
    ov = '0; rel = '1; sample("R4", 1);
    // two clean samples clear
    ov = 5'b00100; rel = 5'b11011; sample("R4", 3);
    ov = '0; rel = '1;              sample("R4", 2);
    ov = 5'b00100; rel = 5'b11011; sample("R4", 5);
    check("R4 cleared count", {alarm, oe}, 2'b11);
    sample("R4", 1);
    check("R4 recount", {alarm, oe}, 2'b01);
    ov = '0; rel = '1; sample("R4", 1);

    // R6: open-wire delay 8 needs 9, clean sample restarts
    ov_dly = 13; ow_dly = 8;
    ow = 5'b01000; sample("R6", 8);
    ow = '0;       sample("R6", 1);
    ow = 5'b01000; sample("R6", 8);
    check("R6 restarted", {alarm, oe}, 2'b11);
    sample("R6", 1);
    check("R6 declared", {alarm, oe}, 2'b01);

    // R7: counted release, restarted by a faulty sample
    ow = '0;       sample("R7", 8);
    ow = 5'b01000; sample("R7", 1);
    ow = '0;       sample("R7", 8);
    check("R7 still flagged", {alarm, oe}, 2'b01);
    sample("R7", 1);
    check("R7 released", {alarm, oe}, 2'b11);

    // R2: unused low cells ignored
    ov_dly = 0; ow_dly = 0; tied = 2'b10;
    ov = 5'b00001; rel = 5'b11110; ow = 5'b00011;
    sample("R2", 3);
    check("R2 masked", {alarm, oe}, 2'b11);
    tied = 2'b01; ov = '0; rel = '1;
    sample("R2", 1);
    check("R2 cell1 active", {alarm, oe}, 2'b01);
    ow = '0; sample("R2", 1);
    check("R2 clean", {alarm, oe}, 2'b11);
    tied = '0;

    // R8: out-of-range delay clamps to 13
    ov_dly = 15; ov = 5'b00001; rel = 5'b11110;
    sample("R8", 13);
    check("R8 before", {alarm, oe}, 2'b11);
    sample("R8", 1);
    check("R8 at 14", {alarm, oe}, 2'b01);
    ov = '0; rel = '1; sample("R8", 1);

    // R1: tick spacing in normal mode
    begin
      int n;
      ov_dly = 0; ov = 5'b10000; rel = 5'b01111; n = 0;
      while (alarm !== 1'b0 && n < 3 * CN) begin step("R1"); n++; end
      check("R1 normal period", 2'(n == CN), 2'd1);
      ov = '0; rel = '1; sample("R1", 1);
    end

    // R9: quick mode shortens delay and period
    ov_dly = 5;
    sup_hi = 1; step("R9"); sup_hi = 0;
    ov = 5'b10000; rel = 5'b01111;
    sample("R9", 1);
    check("R9 quick first", {alarm, oe}, 2'b11);
    sample("R9", 1);
    check("R9 quick delay", {alarm, oe}, 2'b01);
    ov = '0; rel = '1; sample("R9", 1);
    begin
      int n;
      ov_dly = 0; ov = 5'b10000; rel = 5'b01111; n = 0;
      while (alarm !== 1'b0 && n < 3 * CN) begin step("R1 quick"); n++; end
      check("R1 quick period", 2'(n == CQ), 2'd1);
      ov = '0; rel = '1; sample("R1", 1);
    end
    sup_lo = 1; step("R9"); sup_lo = 0;
    ov_dly = 5; ov = 5'b10000; rel = 5'b01111;
    sample("R9", 2);
    check("R9 normal again", {alarm, oe}, 2'b11);
    ov = '0; rel = '1; sample("R9", 2);

    // R10: every style and polarity, faulted and idle
    for (int s = 0; s < 4; s++) begin
      for (int iv = 0; iv < 2; iv++) begin
        style = 2'(s); inv = 1'(iv);
        step("R10 idle");
      end
    end
    ov_dly = 0; ov = 5'b00010; rel = 5'b11101; sample("R10", 1);
    for (int s = 0; s < 4; s++) begin
      for (int iv = 0; iv < 2; iv++) begin
        style = 2'(s); inv = 1'(iv);
        step("R10 fault");
      end
    end
    style = 0; inv = 0;

    // R11: reset clears a flagged fault
    do_reset();
    check("R11 reset clears", {alarm, oe}, 2'b11);
    ov = '0; rel = '1;

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [NC-1:0] o, w;
      int r;
      r = $urandom_range(0, 99);
      o = (r < 35) ? NC'($urandom) & NC'($urandom) : '0;
      w = ($urandom_range(0, 99) < 35) ? NC'($urandom) & NC'($urandom) : '0;
      ov = o; ow = w;
      rel = ($urandom_range(0, 3) == 0) ? (NC'($urandom) & ~o) : ~o;
      if ($urandom_range(0, 19) == 0) tied = OPT'($urandom);
      if ($urandom_range(0, 29) == 0) begin ov_dly = DW'($urandom); ow_dly = DW'($urandom); end
      if ($urandom_range(0, 24) == 0) begin style = 2'($urandom); inv = 1'($urandom); end
      r = $urandom_range(0, 39);
      if (r == 0) begin sup_hi = 1; step("R9 rand"); sup_hi = 0; end
      else if (r == 1) begin sup_lo = 1; step("R9 rand"); sup_lo = 0; end
      sample("R3 R6 rand", 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule